// File: doc/BRIEF.md
# Serial Port Register Bank with Interrupt Masking

This block is the software-facing side of a serial port. A simple word-addressed access port (select, write flag, 10-bit word offset, 16-bit data) reaches a set of configuration registers: baud divisor (integer and fractional parts), line control, port control, buffer fill-level select and interrupt mask. Reads come back one cycle after the access, with a valid strobe.

Transmission is treated as instantaneous. A data write either leaves at once on a one-cycle transmit strobe or, with loopback on, goes straight into the receive buffer. The receive buffer lives outside the block and is reached through push, pop, occupancy count and head-byte signals. Three interrupt sources are kept in a raw status word: receive fill level reached, data written for transmit, and receive data pending. Each source is cleared by writing a one to it. The raw status is ANDed with the mask to form the masked status and one combined interrupt line. Eight fixed identification bytes sit at the top of the offset space.

Top module: `serial_regfile`

## Requirements
- R1: After reset the level-select register reads 0x0012, the other configuration registers and both status words read 0, and `irq` is low.
- R2: Stored widths: fractional divisor keeps bits 5:0, line control bits 7:0, port control is masked with 0xffc7, level select keeps bits 5:0, and the interrupt mask keeps bits 10:0. The integer divisor keeps all 16 bits.
- R3: A data write (offset 0x00) with loopback off pulses `tx_fire` for one cycle with the written low byte on `tx_byte`, and it sets the transmit bit (bit 5) of the raw status (offset 0x0f).
- R4: The masked status (offset 0x11-1 = 0x10) reads raw status AND mask, and `irq` is high exactly when that AND is nonzero.
- R5: A write to offset 0x11 clears each raw status bit written as 1 and leaves the others. A read of 0x11 returns 0.
- R6: With port-control bit 7 (loopback) set, a data write pushes its byte into the receive buffer and does not pulse `tx_fire`. Any rise in buffer occupancy sets raw bit 6 (data pending).
- R7: A data read returns the head byte in bits 7:0 and the receive status in bits 15:8, with overrun at bit 11, and pops one byte. After the pop, raw bit 4 clears if the occupancy is below the trigger level and raw bit 6 clears if the buffer is empty. Overrun survives the read.
- R8: A loopback data write while the buffer holds DEPTH bytes stores nothing and sets overrun (bit 3 of the receive status at offset 0x01). Any write to offset 0x01 clears the receive status.
- R9: The flags word (offset 0x06) always has bit 7 (transmit empty) set. Bit 6 is set at occupancy DEPTH and bit 4 at occupancy 0.
- R10: Raw bit 4 is set when occupancy moves from below to at-or-above the trigger level. The trigger level is 1 when line-control bit 4 (buffer enable) is clear. Otherwise it follows level-select bits 5:3: 0 gives DEPTH/8, 1 gives DEPTH/4, 2 gives DEPTH/2, 3 gives 3·DEPTH/4, 4 gives 7·DEPTH/8, and higher values give DEPTH.
- R11: Offsets 0x3f8 to 0x3ff read 0x11, 0x10, 0x24, 0x00, 0x0d, 0xf0, 0x05, 0xb1. Unassigned offsets read 0 and ignore writes. Writes to the raw status, masked status and flags offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| tx_fire | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmitted byte |
| rxq_count | input | 5 | Receive buffer occupancy |
| rxq_head | input | 8 | Oldest byte in the receive buffer |
| rxq_pop | output | 1 | Remove the head byte |
| rxq_push | output | 1 | Append rxq_wbyte to the buffer |
| rxq_wbyte | output | 8 | Byte to append (loopback) |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest situation to reach is overrun together with the fill-level interrupt. Getting there needs the buffer filled to exactly DEPTH and one more loopback write. That overrun must then persist through a data read that moves occupancy back and forth across the trigger. The stimulus turns on loopback and the buffer enable, then pushes bytes one by one through data writes. It reads raw status just below and just at the trigger level, checks the full flag, and overflows the buffer. It then drains the buffer through data reads, watching bit 4 fall exactly when the occupancy drops below the trigger. A second level-select value is used to show that the trigger follows the select field.

// File: rtl/serial_regfile_pkg.sv
package serial_regfile_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFF_DATA  = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_RSTAT = 10'h001;
  localparam logic [ADDR_W-1:0] OFF_FLAGS = 10'h006;
  localparam logic [ADDR_W-1:0] OFF_DIVI  = 10'h009;
  localparam logic [ADDR_W-1:0] OFF_DIVF  = 10'h00a;
  localparam logic [ADDR_W-1:0] OFF_LINE  = 10'h00b;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 10'h00c;
  localparam logic [ADDR_W-1:0] OFF_LEVEL = 10'h00d;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 10'h00e;
  localparam logic [ADDR_W-1:0] OFF_RAW   = 10'h00f;
  localparam logic [ADDR_W-1:0] OFF_MSKD  = 10'h010;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 10'h011;

  localparam logic [15:0] CTRL_KEEP  = 16'hffc7;
  localparam int          LOOP_BIT   = 7;
  localparam int          BUF_EN_BIT = 4;
  localparam logic [5:0]  LEVEL_RST  = 6'h12;

  // identification words, low byte first at the top eight offsets
  localparam logic [63:0] ID_WORDS = 64'hb105f00d_00241011;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    return ID_WORDS[idx*8 +: 8];
  endfunction
endpackage

// File: rtl/serial_regfile_cfg.sv
module serial_regfile_cfg
  import serial_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [15:0]       divi,
  output logic [5:0]        divf,
  output logic [7:0]        line,
  output logic [15:0]       ctrl,
  output logic [5:0]        level,
  output logic [10:0]       mask
);
  logic [15:0] divi_n, ctrl_n;
  logic [5:0]  divf_n, level_n;
  logic [7:0]  line_n;
  logic [10:0] mask_n;

  always_comb begin
    divi_n  = divi;
    divf_n  = divf;
    line_n  = line;
    ctrl_n  = ctrl;
    level_n = level;
    mask_n  = mask;
    if (wr_en) begin
      case (addr)
        OFF_DIVI:  divi_n  = wdata;
        OFF_DIVF:  divf_n  = wdata[5:0];
        OFF_LINE:  line_n  = wdata[7:0];
        OFF_CTRL:  ctrl_n  = wdata & CTRL_KEEP;
        OFF_LEVEL: level_n = wdata[5:0];
        OFF_MASK:  mask_n  = wdata[10:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divi  <= '0;
      divf  <= '0;
      line  <= '0;
      ctrl  <= '0;
      level <= LEVEL_RST;
      mask  <= '0;
    end else begin
      divi  <= divi_n;
      divf  <= divf_n;
      line  <= line_n;
      ctrl  <= ctrl_n;
      level <= level_n;
      mask  <= mask_n;
    end
  end
endmodule

// File: rtl/serial_regfile_intr.sv
module serial_regfile_intr #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_set,
  input  logic          clr_en,
  input  logic [2:0]    clr_bits,   // raw bits 6:4
  input  logic          pop,
  input  logic [CW-1:0] count,
  input  logic          buf_en,
  input  logic [2:0]    rx_sel,
  input  logic          ovf,
  input  logic          oe_clr,
  output logic [10:0]   ris,
  output logic          oe
);
  localparam logic [CW-1:0] LV0 = CW'(DEPTH / 8);
  localparam logic [CW-1:0] LV1 = CW'(DEPTH / 4);
  localparam logic [CW-1:0] LV2 = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LV3 = CW'(DEPTH * 3 / 4);
  localparam logic [CW-1:0] LV4 = CW'(DEPTH * 7 / 8);
  localparam logic [CW-1:0] LVF = CW'(DEPTH);

  logic          rx_q, tx_q, rt_q, oe_q;
  logic          rx_n, tx_n, rt_n, oe_n;
  logic [CW-1:0] cnt_prev, trig, after_pop;

  always_comb begin
    if (!buf_en) trig = CW'(1);
    else begin
      case (rx_sel)
        3'd0:    trig = LV0;
        3'd1:    trig = LV1;
        3'd2:    trig = LV2;
        3'd3:    trig = LV3;
        3'd4:    trig = LV4;
        default: trig = LVF;
      endcase
    end
  end

  assign after_pop = count - CW'(1);

  always_comb begin
    rx_n = rx_q;
    tx_n = tx_q;
    rt_n = rt_q;
    oe_n = oe_q;
    if (clr_en) begin
      if (clr_bits[0]) rx_n = 1'b0;
      if (clr_bits[1]) tx_n = 1'b0;
      if (clr_bits[2]) rt_n = 1'b0;
    end
    if (pop) begin
      if (after_pop < trig) rx_n = 1'b0;
      if (after_pop == '0)  rt_n = 1'b0;
    end
    if (tx_set) tx_n = 1'b1;
    if (cnt_prev < trig && count >= trig) rx_n = 1'b1;
    if (count > cnt_prev) rt_n = 1'b1;
    if (oe_clr) oe_n = 1'b0;
    if (ovf)    oe_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q     <= 1'b0;
      tx_q     <= 1'b0;
      rt_q     <= 1'b0;
      oe_q     <= 1'b0;
      cnt_prev <= '0;
    end else begin
      rx_q     <= rx_n;
      tx_q     <= tx_n;
      rt_q     <= rt_n;
      oe_q     <= oe_n;
      cnt_prev <= count;
    end
  end

  assign ris = {4'b0, rt_q, tx_q, rx_q, 4'b0};
  assign oe  = oe_q;
endmodule

// File: rtl/serial_regfile.sv
module serial_regfile
  import serial_regfile_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              tx_fire,
  output logic [7:0]        tx_byte,
  input  logic [CW-1:0]     rxq_count,
  input  logic [7:0]        rxq_head,
  output logic              rxq_pop,
  output logic              rxq_push,
  output logic [7:0]        rxq_wbyte,
  output logic              irq
);
  logic [15:0] divi, ctrl;
  logic [5:0]  divf, level;
  logic [7:0]  line;
  logic [10:0] mask, ris;
  logic        oe;
  logic        acc_wr, acc_rd, data_wr, loop_on, buf_full, buf_empty;
  logic [DATA_W-1:0] rd_n;

  assign acc_wr    = bus_sel & bus_wr;
  assign acc_rd    = bus_sel & ~bus_wr;
  assign data_wr   = acc_wr & (bus_addr == OFF_DATA);
  assign loop_on   = ctrl[LOOP_BIT];
  assign buf_full  = (rxq_count == CW'(DEPTH));
  assign buf_empty = (rxq_count == '0);

  assign tx_fire   = data_wr & ~loop_on;
  assign tx_byte   = bus_wdata[7:0];
  assign rxq_push  = data_wr & loop_on & ~buf_full;
  assign rxq_wbyte = bus_wdata[7:0];
  assign rxq_pop   = acc_rd & (bus_addr == OFF_DATA) & ~buf_empty;

  serial_regfile_cfg u_cfg (
    .clk, .rst_n, .wr_en(acc_wr), .addr(bus_addr), .wdata(bus_wdata),
    .divi, .divf, .line, .ctrl, .level, .mask
  );

  serial_regfile_intr #(.DEPTH(DEPTH)) u_intr (
    .clk, .rst_n,
    .tx_set   (data_wr),
    .clr_en   (acc_wr & (bus_addr == OFF_CLR)),
    .clr_bits (bus_wdata[6:4]),
    .pop      (rxq_pop),
    .count    (rxq_count),
    .buf_en   (line[BUF_EN_BIT]),
    .rx_sel   (level[5:3]),
    .ovf      (data_wr & loop_on & buf_full),
    .oe_clr   (acc_wr & (bus_addr == OFF_RSTAT)),
    .ris, .oe
  );

  always_comb begin
    rd_n = '0;
    if (bus_addr[ADDR_W-1:3] == '1) begin
      rd_n = {8'h00, id_byte(bus_addr[2:0])};
    end else begin
      case (bus_addr)
        OFF_DATA:  rd_n = {4'h0, oe, 3'b000, rxq_head};
        OFF_RSTAT: rd_n = {12'h000, oe, 3'b000};
        OFF_FLAGS: rd_n = {8'h00, 1'b1, buf_full, 1'b0, buf_empty, 4'h0};
        OFF_DIVI:  rd_n = divi;
        OFF_DIVF:  rd_n = {10'h000, divf};
        OFF_LINE:  rd_n = {8'h00, line};
        OFF_CTRL:  rd_n = ctrl;
        OFF_LEVEL: rd_n = {10'h000, level};
        OFF_MASK:  rd_n = {5'h00, mask};
        OFF_RAW:   rd_n = {5'h00, ris};
        OFF_MSKD:  rd_n = {5'h00, ris & mask};
        default:   rd_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= acc_rd;
      if (acc_rd) bus_rdata <= rd_n;
    end
  end

  assign irq = |(ris & mask);
endmodule

// File: rtl/serial_regfile_chk.sv
module serial_regfile_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [9:0]    bus_addr,
  input logic [15:0]   bus_rdata,
  input logic          bus_rvalid,
  input logic          tx_fire,
  input logic          rxq_pop,
  input logic [CW-1:0] rxq_count,
  input logic [10:0]   ris,
  input logic [15:0]   ctrl,
  input logic          oe
);
  // R3
  tx_raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 10'h000 && !ctrl[7]) |=> ris[5]);
  // R6
  loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 10'h000 && ctrl[7]) |-> !tx_fire);
  // R9
  flags_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 10'h006) |=> (bus_rvalid && bus_rdata[7]));
  // R5
  clr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 10'h011) |=> (bus_rdata == 16'h0000));
  // R7
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_pop |-> (rxq_count != '0));
  // R8
  rstat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 10'h001) |=> !oe);
endmodule

bind serial_regfile serial_regfile_chk #(.DEPTH(DEPTH)) u_chk (
  .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_rdata, .bus_rvalid,
  .tx_fire, .rxq_pop, .rxq_count, .ris, .ctrl, .oe
);

// File: tb/test_serial_regfile.sv
module test_serial_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid, tx_fire, rxq_pop, rxq_push, irq;
  logic [7:0]  tx_byte, rxq_wbyte;
  logic [4:0]  rxq_count = '0;
  logic [7:0]  rxq_head = '0;
  logic        ext_req = 1'b0;
  logic [7:0]  ext_byte = '0;

  int checks = 0, errors = 0, tx_seen = 0;
  logic [7:0]  tx_last = '0;
  logic [7:0]  fq[$];
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  serial_regfile i_serial_regfile (.*);

  // receive buffer model
  always @(posedge clk) begin
    if (rxq_pop && fq.size() > 0) void'(fq.pop_front());
    if (rxq_push) fq.push_back(rxq_wbyte);
    if (ext_req)  fq.push_back(ext_byte);
    rxq_count <= 5'(fq.size());
    rxq_head  <= (fq.size() > 0) ? fq[0] : 8'h00;
    if (tx_fire) begin tx_seen <= tx_seen + 1; tx_last <= tx_byte; end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compare read results in order
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) chk("unexpected read", bus_rdata, 16'hxxxx);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [9:0] a, logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    @(negedge clk);
  endtask

  task automatic rd(logic [9:0] a, logic [15:0] e, string req);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk); bus_sel = 0;
    @(negedge clk);
  endtask

  task automatic ext_push(logic [7:0] b);
    @(negedge clk); ext_req = 1; ext_byte = b;
    @(negedge clk); ext_req = 0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int txb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq", {15'b0, irq}, 16'h0000);
    rd(10'h006, 16'h0090, "R9 flags empty");
    rd(10'h00d, 16'h0012, "R1 level reset");
    rd(10'h00c, 16'h0000, "R1 ctrl reset");
    rd(10'h00f, 16'h0000, "R1 raw reset");

    // R2 masking
    wr(10'h009, 16'hffff); rd(10'h009, 16'hffff, "R2 int div");
    wr(10'h00a, 16'hffff); rd(10'h00a, 16'h003f, "R2 frac div");
    wr(10'h00b, 16'hffff); rd(10'h00b, 16'h00ff, "R2 line");
    wr(10'h00b, 16'h0000);
    wr(10'h00c, 16'hffff); rd(10'h00c, 16'hffc7, "R2 ctrl");
    wr(10'h00c, 16'h0000);
    wr(10'h00e, 16'hffff); rd(10'h00e, 16'h07ff, "R2 mask");
    wr(10'h00e, 16'h0000);
    wr(10'h00d, 16'hffff); rd(10'h00d, 16'h003f, "R2 level");
    wr(10'h00d, 16'h0012);

    // R3 / R4 / R5 transmit interrupt
    wr(10'h000, 16'h013c);
    chk("R3 tx count", 16'(tx_seen), 16'd1);
    chk("R3 tx byte", {8'h0, tx_last}, 16'h003c);
    rd(10'h00f, 16'h0020, "R3 raw tx");
    rd(10'h010, 16'h0000, "R4 masked none");
    chk("R4 irq masked off", {15'b0, irq}, 16'h0000);
    wr(10'h00e, 16'h0020);
    chk("R4 irq on", {15'b0, irq}, 16'h0001);
    rd(10'h010, 16'h0020, "R4 masked tx");
    wr(10'h011, 16'h0010);
    rd(10'h00f, 16'h0020, "R5 other bit kept");
    wr(10'h011, 16'h0020);
    rd(10'h00f, 16'h0000, "R5 cleared");
    chk("R5 irq off", {15'b0, irq}, 16'h0000);
    rd(10'h011, 16'h0000, "R5 clear reads 0");

    // R6 / R7 loopback, buffer disabled
    wr(10'h00c, 16'h0080);
    txb = tx_seen;
    wr(10'h000, 16'h005a);
    chk("R6 no tx in loopback", 16'(tx_seen), 16'(txb));
    rd(10'h006, 16'h0080, "R9 flags mid");
    rd(10'h00f, 16'h0070, "R6 raw after loopback");
    rd(10'h000, 16'h005a, "R7 data read");
    rd(10'h00f, 16'h0020, "R7 rx bits cleared");
    rd(10'h006, 16'h0090, "R9 flags empty again");

    // R10 / R8 / R9 buffer enabled, trigger 8
    wr(10'h011, 16'h007f);
    wr(10'h00b, 16'h0010);
    for (int i = 0; i < 7; i++) wr(10'h000, 16'(8'h10 + i));
    rd(10'h00f, 16'h0060, "R10 below trigger");
    wr(10'h000, 16'h0017);
    rd(10'h00f, 16'h0070, "R10 at trigger");
    for (int i = 8; i < 16; i++) wr(10'h000, 16'(8'h10 + i));
    rd(10'h006, 16'h00c0, "R9 flags full");
    wr(10'h000, 16'h00ee);
    rd(10'h001, 16'h0008, "R8 overrun set");
    rd(10'h000, 16'h0810, "R7 status in upper byte");
    rd(10'h001, 16'h0008, "R7 overrun survives read");
    rd(10'h00f, 16'h0070, "R7 rx kept above trigger");
    wr(10'h001, 16'h0000);
    rd(10'h001, 16'h0000, "R8 status cleared");
    for (int i = 1; i < 8; i++) rd(10'h000, 16'(8'h10 + i), "R7 drain");
    rd(10'h00f, 16'h0070, "R7 rx at trigger");
    rd(10'h000, 16'h0018, "R7 drain");
    rd(10'h00f, 16'h0060, "R7 rx below trigger");
    for (int i = 9; i < 16; i++) rd(10'h000, 16'(8'h10 + i), "R7 drain");
    rd(10'h00f, 16'h0020, "R7 rt empty");

    // R10 level select 1 -> trigger 4
    wr(10'h00d, 16'h0008);
    wr(10'h011, 16'h007f);
    for (int i = 0; i < 3; i++) wr(10'h000, 16'(8'h40 + i));
    rd(10'h00f, 16'h0060, "R10 sel1 below");
    wr(10'h000, 16'h0043);
    rd(10'h00f, 16'h0070, "R10 sel1 reached");
    for (int i = 0; i < 4; i++) rd(10'h000, 16'(8'h40 + i), "R10 drain");

    // R6 arrival from the receive side, R4 irq
    wr(10'h00c, 16'h0000);
    wr(10'h00b, 16'h0000);
    wr(10'h011, 16'h007f);
    wr(10'h00e, 16'h0000);
    ext_push(8'ha5);
    rd(10'h00f, 16'h0050, "R6 arrival raw");
    wr(10'h00e, 16'h0040);
    chk("R4 irq rt", {15'b0, irq}, 16'h0001);
    rd(10'h000, 16'h00a5, "R7 arrival read");
    chk("R4 irq gone", {15'b0, irq}, 16'h0000);

    // R11 id and ignored writes
    rd(10'h3f8, 16'h0011, "R11 id0");
    rd(10'h3f9, 16'h0010, "R11 id1");
    rd(10'h3fa, 16'h0024, "R11 id2");
    rd(10'h3fb, 16'h0000, "R11 id3");
    rd(10'h3fc, 16'h000d, "R11 id4");
    rd(10'h3fd, 16'h00f0, "R11 id5");
    rd(10'h3fe, 16'h0005, "R11 id6");
    rd(10'h3ff, 16'h00b1, "R11 id7");
    wr(10'h020, 16'hffff); rd(10'h020, 16'h0000, "R11 unassigned");
    wr(10'h00f, 16'hffff); rd(10'h00f, 16'h0000, "R11 raw read-only");
    wr(10'h010, 16'hffff); rd(10'h010, 16'h0000, "R11 masked read-only");
    wr(10'h006, 16'hffff); rd(10'h006, 16'h0090, "R11 flags read-only");
    chk("R11 irq", {15'b0, irq}, 16'h0000);
    chk("R3 tx total", 16'(tx_seen), 16'd1);

    repeat (3) @(negedge clk);
    chk("pending reads", 16'(exp_q.size()), 16'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule